// File: doc/BRIEF.md
# Flash Program and Chip-Erase Sequencer

This block sits on the host side of a byte-wide parallel flash. It runs the device's closed-loop algorithms so software does not have to. A one-cycle program request carries an address and a data byte. The sequencer then issues program pulses, each followed by a verify read, until the byte reads back correctly or a pulse limit is reached. A one-cycle chip-erase request first programs every location to 00H using the same loop. It then issues erase pulses and walks the address range with erase-verify reads. When a location does not read FFH, it pulses again from that location. Every sequence ends with two read-mode commands, after which the programming-supply enable is released.

Bus timing is expressed in clock cycles. A strobe-width parameter sets how long chip-enable together with write-enable or output-enable stays low. The pulse and verify waits are counted by a down-counter loaded from parameters. The states are:

- Idle.
- Prepare.
- Program setup, program data, program wait, program-verify command, verify wait, program read and program check.
- Erase setup, erase command, erase wait, erase-verify command, erase-verify wait, erase read and erase check.
- First reset write, second reset write and finish.

Transitions:

- Idle goes to prepare when a request arrives.
- Each bus or wait state moves to its successor when its bus cycle acknowledges or its timer expires.
- Program check branches to the next preprogram address, to erase setup, to another program pulse, or to the reset writes.
- Erase check branches to the next erase-verify address, to another erase pulse, or to the reset writes.
- Finish returns to idle and posts the result.

Top module: `fseq_ctrl`

## Requirements
- R1: After reset, and whenever idle, busy, done and fail are 0 (done and fail until a first operation ends). Chip-enable, write-enable and output-enable are high and vpp_en is 0.
- R2: A program request raises vpp_en and busy, latches address and data, and clears the pulse count. Each pulse writes 40H and then the data byte to the latched address. vpp_en is 1 during every write cycle.
- R3: After each program data write, the sequencer waits at least T_PGM cycles and then writes C0H. It then waits at least T_VFY cycles before the verify read.
- R4: If the verify read differs from the data, another pulse follows. After MAX_PPULSE pulses without a match, the operation ends in fail.
- R5: A chip-erase request first programs every address to 00H, from 0 upward, using the R2–R4 loop with a fresh pulse count per address. No 20H write occurs before that finishes.
- R6: An erase pulse writes 20H twice, waits at least T_ERS cycles, then writes A0H to the current address before the read.
- R7: In erase verify, a byte reading FFH advances to the next address with only an A0H write and a read, and no new pulse. A byte reading anything else triggers another erase pulse at that address. After MAX_EPULSE erase pulses in total, the operation ends in fail. Passing the last address ends in done.
- R8: Every operation, whether it passes or fails, ends with two FFH writes. vpp_en drops before done or fail is raised.
- R9: busy, done and fail are never more than one high at a time. done or fail holds until the next accepted request.
- R10: Requests, address and data presented while busy are ignored.
- R11: Write-enable and output-enable are never low together, and either one low implies chip-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pgm | input | 1 | One-cycle request to program a byte (wins over erase) |
| start_ers | input | 1 | One-cycle request to erase the whole device |
| host_addr | input | AW | Byte address for a program request |
| host_data | input | 8 | Byte value for a program request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence passed |
| fail | output | 1 | Last sequence hit a pulse limit |
| vpp_en | output | 1 | Programming-supply enable |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven to the flash |
| fl_din | input | 8 | Data read from the flash |
| fl_drive | output | 1 | Host drives the data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest paths to reach are the erase retry from a middle address and the exhaustion of the erase pulse budget. Both need a device that erases some locations only after several pulses. The bench models the flash with a per-address count of pulses required before the byte turns FFH. It also has a counter of program pulses to swallow, so it can force retries, exhausted program attempts, and an erase that stalls partway through the walk. A scoreboard holds every expected bus write of each sequence, in order, so any missing, extra or reordered cycle is visible.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_PGM_SETUP = 8'h40;
    localparam logic [BYTE_W-1:0] CMD_PGM_VFY   = 8'hC0;
    localparam logic [BYTE_W-1:0] CMD_ERS       = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_ERS_VFY   = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_READ      = 8'hFF;
    localparam logic [BYTE_W-1:0] BYTE_ERASED   = 8'hFF;
    localparam logic [BYTE_W-1:0] BYTE_ZERO     = 8'h00;

    typedef enum logic [4:0] {
        S_IDLE, S_PREP,
        S_P_SETUP, S_P_DATA, S_P_WAIT, S_P_VCMD, S_P_VWAIT, S_P_READ, S_P_CHECK,
        S_E_SETUP, S_E_CMD, S_E_WAIT, S_E_VCMD, S_E_VWAIT, S_E_READ, S_E_CHECK,
        S_R_ONE, S_R_TWO, S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bus_state_e;

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fseq_bus.sv
module fseq_bus
    import fseq_pkg::*;
#(
    parameter int STB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd,
    input  logic [BYTE_W-1:0] din,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata
);
    localparam int CW = $clog2(STB) + 1;

    bus_state_e    st;
    logic [CW-1:0] cnt;
    logic          rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= B_IDLE;
            cnt   <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
        end else begin
            unique case (st)
                B_IDLE: if (go) begin
                    st   <= B_ACT;
                    cnt  <= '0;
                    rd_q <= rd;
                end
                B_ACT: if (cnt == CW'(STB - 1)) begin
                    st <= B_REC;
                    if (rd_q) rdata <= din;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                B_REC:  st <= B_IDLE;
                default: st <= B_IDLE;
            endcase
        end
    end

    assign ce_n = (st != B_ACT);
    assign we_n = !((st == B_ACT) && !rd_q);
    assign oe_n = !((st == B_ACT) && rd_q);
    assign ack  = (st == B_REC);
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int AW         = 18,
    parameter int T_PGM      = 500,
    parameter int T_VFY      = 300,
    parameter int T_ERS      = 500000,
    parameter int STB        = 3,
    parameter int MAX_PPULSE = 25,
    parameter int MAX_EPULSE = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pgm,
    input  logic              start_ers,
    input  logic [AW-1:0]     host_addr,
    input  logic [BYTE_W-1:0] host_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              vpp_en,
    output logic [AW-1:0]     fl_addr,
    output logic [BYTE_W-1:0] fl_dout,
    input  logic [BYTE_W-1:0] fl_din,
    output logic              fl_drive,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int TMAX1 = (T_PGM > T_VFY) ? T_PGM : T_VFY;
    localparam int TMAX  = (TMAX1 > T_ERS) ? TMAX1 : T_ERS;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int PMAX  = (MAX_EPULSE > MAX_PPULSE) ? MAX_EPULSE : MAX_PPULSE;
    localparam int PW    = $clog2(PMAX) + 1;
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    seq_state_e        state;
    logic [AW-1:0]     addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [PW-1:0]     pcnt;
    logic              ers_q, pass_q, armed, vpp_q, done_q, fail_q;

    logic              wr_st, rd_st, wt_st;
    logic [TW-1:0]     wt_val;
    logic [BYTE_W-1:0] cmd;
    logic              bus_go, bus_ack, tmr_load, tmr_exp, step_done;
    logic [BYTE_W-1:0] rdata;

    // Output decode: what each state drives on the bus or the timer
    always_comb begin
        wr_st  = 1'b0;
        rd_st  = 1'b0;
        wt_st  = 1'b0;
        wt_val = '0;
        cmd    = CMD_READ;
        unique case (state)
            S_P_SETUP:            begin wr_st = 1'b1; cmd = CMD_PGM_SETUP; end
            S_P_DATA:             begin wr_st = 1'b1; cmd = data_q;        end
            S_P_WAIT:             begin wt_st = 1'b1; wt_val = TW'(T_PGM); end
            S_P_VCMD:             begin wr_st = 1'b1; cmd = CMD_PGM_VFY;   end
            S_P_VWAIT, S_E_VWAIT: begin wt_st = 1'b1; wt_val = TW'(T_VFY); end
            S_P_READ, S_E_READ:   rd_st = 1'b1;
            S_E_SETUP, S_E_CMD:   begin wr_st = 1'b1; cmd = CMD_ERS;       end
            S_E_WAIT:             begin wt_st = 1'b1; wt_val = TW'(T_ERS); end
            S_E_VCMD:             begin wr_st = 1'b1; cmd = CMD_ERS_VFY;   end
            S_R_ONE, S_R_TWO:     begin wr_st = 1'b1; cmd = CMD_READ;      end
            default: ;
        endcase
    end

    assign bus_go    = (wr_st | rd_st) & !armed;
    assign tmr_load  = wt_st & !armed;
    assign step_done = armed & (((wr_st | rd_st) & bus_ack) | (wt_st & tmr_exp));

    // State register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            data_q <= '0;
            pcnt   <= '0;
            ers_q  <= 1'b0;
            pass_q <= 1'b0;
            armed  <= 1'b0;
            vpp_q  <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (bus_go | tmr_load) armed <= 1'b1;
            if (step_done)         armed <= 1'b0;
            unique case (state)
                S_IDLE: if (start_pgm | start_ers) begin
                    state  <= S_PREP;
                    vpp_q  <= 1'b1;
                    done_q <= 1'b0;
                    fail_q <= 1'b0;
                    pcnt   <= '0;
                    ers_q  <= !start_pgm;
                    addr_q <= start_pgm ? host_addr : '0;
                    data_q <= start_pgm ? host_data : BYTE_ZERO;
                end
                S_PREP:    state <= S_P_SETUP;
                S_P_SETUP: if (step_done) state <= S_P_DATA;
                S_P_DATA:  if (step_done) state <= S_P_WAIT;
                S_P_WAIT:  if (step_done) state <= S_P_VCMD;
                S_P_VCMD:  if (step_done) state <= S_P_VWAIT;
                S_P_VWAIT: if (step_done) state <= S_P_READ;
                S_P_READ:  if (step_done) state <= S_P_CHECK;
                S_P_CHECK: begin
                    if (rdata == data_q) begin
                        pcnt <= '0;
                        if (!ers_q) begin
                            pass_q <= 1'b1;
                            state  <= S_R_ONE;
                        end else if (addr_q == LAST_ADDR) begin
                            addr_q <= '0;
                            state  <= S_E_SETUP;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                            state  <= S_P_SETUP;
                        end
                    end else if (pcnt == PW'(MAX_PPULSE - 1)) begin
                        pass_q <= 1'b0;
                        state  <= S_R_ONE;
                    end else begin
                        pcnt  <= pcnt + 1'b1;
                        state <= S_P_SETUP;
                    end
                end
                S_E_SETUP: if (step_done) state <= S_E_CMD;
                S_E_CMD:   if (step_done) state <= S_E_WAIT;
                S_E_WAIT:  if (step_done) state <= S_E_VCMD;
                S_E_VCMD:  if (step_done) state <= S_E_VWAIT;
                S_E_VWAIT: if (step_done) state <= S_E_READ;
                S_E_READ:  if (step_done) state <= S_E_CHECK;
                S_E_CHECK: begin
                    if (rdata == BYTE_ERASED) begin
                        if (addr_q == LAST_ADDR) begin
                            pass_q <= 1'b1;
                            state  <= S_R_ONE;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                            state  <= S_E_VCMD;
                        end
                    end else if (pcnt == PW'(MAX_EPULSE - 1)) begin
                        pass_q <= 1'b0;
                        state  <= S_R_ONE;
                    end else begin
                        pcnt  <= pcnt + 1'b1;
                        state <= S_E_SETUP;
                    end
                end
                S_R_ONE: if (step_done) state <= S_R_TWO;
                S_R_TWO: if (step_done) state <= S_FINISH;
                S_FINISH: begin
                    vpp_q  <= 1'b0;
                    done_q <= pass_q;
                    fail_q <= !pass_q;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    fseq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .val     (wt_val),
        .expired (tmr_exp)
    );

    fseq_bus #(.STB(STB)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (bus_go),
        .rd    (rd_st),
        .din   (fl_din),
        .ce_n  (fl_ce_n),
        .we_n  (fl_we_n),
        .oe_n  (fl_oe_n),
        .ack   (bus_ack),
        .rdata (rdata)
    );

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign fail     = fail_q;
    assign vpp_en   = vpp_q;
    assign fl_addr  = addr_q;
    assign fl_dout  = cmd;
    assign fl_drive = wr_st;
endmodule

// File: rtl/fseq_ctrl_chk.sv
module fseq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_pgm,
    input logic start_ers,
    input logic busy,
    input logic done,
    input logic fail,
    input logic vpp_en,
    input logic fl_ce_n,
    input logic fl_we_n,
    input logic fl_oe_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !vpp_en)); // R1

    AST_WRITE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> vpp_en); // R2

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, fail})); // R9

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || fail) && !start_pgm && !start_ers) |=> $stable({done, fail})); // R9

    AST_SUPPLY_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) || $rose(fail)) |-> !vpp_en); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n)); // R11

    AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R11
endmodule

bind fseq_ctrl fseq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_pgm (start_pgm),
    .start_ers (start_ers),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .vpp_en    (vpp_en),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/fseq_ctrl_bench.sv
module fseq_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int AW = 4;
    localparam int N = 1 << AW;
    localparam int T_PGM = 20, T_VFY = 6, T_ERS = 40, STB = 2;
    localparam int MAX_P = 25, MAX_E = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_pgm = 1'b0, start_ers = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic busy, done, fail, vpp_en, fl_drive, fl_ce_n, fl_we_n, fl_oe_n;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dout, fl_din;

    logic [7:0] mem [N];
    int need [N];
    int ers_count = 0, pgm_fail_left = 0;
    logic [7:0] last_cmd = 8'h00;
    int errors = 0, checks = 0, cyc = 0;
    string cur_req = "R2";
    logic [AW+7:0] exp_q [$];

    always #(CLK_P/2) clk = ~clk;
    assign fl_din = mem[fl_addr];

    fseq_ctrl #(.AW(AW), .T_PGM(T_PGM), .T_VFY(T_VFY), .T_ERS(T_ERS), .STB(STB),
                .MAX_PPULSE(MAX_P), .MAX_EPULSE(MAX_E)) u_fseq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .start_ers(start_ers),
        .host_addr(host_addr), .host_data(host_data), .busy(busy), .done(done),
        .fail(fail), .vpp_en(vpp_en), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_din(fl_din), .fl_drive(fl_drive), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_gap(string tag, int gap, int t, string what);
        checks++;
        if (gap < t || gap > t + 6) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", tag, what, gap, t, t + 6);
        end
    endtask

    // Monitor: flash model plus scoreboard pop and wait-time measurement
    int kind = 0;   // 1 program data, 2 program verify cmd, 3 erase pulse
    int t_rise = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_we && !fl_we_n) begin
                if (kind == 1) chk_gap("R3", cyc - t_rise, T_PGM, "program wait");
                if (kind == 3) chk_gap("R6", cyc - t_rise, T_ERS, "erase wait");
            end
            if (prev_oe && !fl_oe_n && kind == 2)
                chk_gap("R3", cyc - t_rise, T_VFY, "verify wait");
            if (!prev_we && fl_we_n) begin
                t_rise = cyc;
                chk("R2", int'(vpp_en), 1, "supply during write");
                if (exp_q.size() == 0) begin
                    chk(cur_req, int'({fl_addr, fl_dout}), -1, "unexpected write");
                end else begin
                    chk(cur_req, int'({fl_addr, fl_dout}), int'(exp_q.pop_front()), "bus write");
                end
                if (last_cmd == 8'h40) begin
                    kind = 1;
                    if (pgm_fail_left > 0) pgm_fail_left--;
                    else mem[fl_addr] = mem[fl_addr] & fl_dout;
                    last_cmd = 8'h00;
                end else if (last_cmd == 8'h20 && fl_dout == 8'h20) begin
                    kind = 3;
                    ers_count++;
                    for (int i = 0; i < N; i++) if (ers_count >= need[i]) mem[i] = 8'hFF;
                    last_cmd = 8'h00;
                end else begin
                    kind = (fl_dout == 8'hC0) ? 2 : 0;
                    last_cmd = fl_dout;
                end
            end
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    task automatic push(int a, int d);
        exp_q.push_back({AW'(a), 8'(d)});
    endtask

    task automatic exp_pgm(int a, int d, int pulses);
        for (int p = 0; p < pulses; p++) begin
            push(a, 8'h40); push(a, d); push(a, 8'hC0);
        end
        push(a, 8'hFF); push(a, 8'hFF);
    endtask

    task automatic exp_ers(output bit ok);
        int a, p;
        for (int i = 0; i < N; i++) begin
            push(i, 8'h40); push(i, 8'h00); push(i, 8'hC0);
        end
        a = 0; p = 1; ok = 1'b1;
        push(0, 8'h20); push(0, 8'h20);
        forever begin
            push(a, 8'hA0);
            if (p >= need[a]) begin
                if (a == N - 1) break;
                a++;
            end else if (p == MAX_E) begin
                ok = 1'b0;
                break;
            end else begin
                p++;
                push(a, 8'h20); push(a, 8'h20);
            end
        end
        push(a, 8'hFF); push(a, 8'hFF);
    endtask

    task automatic fill_mem(logic [7:0] v);
        for (int i = 0; i < N; i++) mem[i] = v;
    endtask

    task automatic pulse_start(bit ers, int a, int d);
        @(negedge clk);
        host_addr = AW'(a); host_data = 8'(d);
        start_pgm = !ers; start_ers = ers;
        @(negedge clk);
        start_pgm = 1'b0; start_ers = 1'b0;
    endtask

    task automatic wait_end(string tag, bit exp_ok);
        while (!(done || fail)) @(negedge clk);
        chk(tag, int'(done), int'(exp_ok), "done");
        chk(tag, int'(fail), int'(!exp_ok), "fail");
        chk("R8", int'(vpp_en), 0, "supply off at end");
        chk("R8", exp_q.size(), 0, "writes left in scoreboard");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        fill_mem(8'hFF);
        for (int i = 0; i < N; i++) need[i] = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'({busy, done, fail, vpp_en}), 0, "status after reset");
        chk("R1", int'({fl_ce_n, fl_we_n, fl_oe_n}), 7, "strobes after reset");

        // R2/R3 program passing first pulse; R10 requests mid-operation ignored
        cur_req = "R2";
        exp_pgm(6, 8'h5A, 1);
        pulse_start(1'b0, 6, 8'h5A);
        chk("R2", int'(busy), 1, "busy after request");
        repeat (30) @(negedge clk);
        pulse_start(1'b1, 3, 8'h00);   // R10: erase and new address while busy
        pulse_start(1'b0, 3, 8'h00);
        wait_end("R2", 1'b1);
        chk("R2", int'(mem[6]), 8'h5A, "programmed byte");
        chk("R10", int'(mem[3]), 8'hFF, "byte untouched by ignored request");
        repeat (15) @(negedge clk);
        chk("R9", int'({busy, done, fail}), 3'b010, "done holds");

        // R4 program needing three pulses
        cur_req = "R4";
        pgm_fail_left = 2;
        exp_pgm(9, 8'h33, 3);
        pulse_start(1'b0, 9, 8'h33);
        chk("R9", int'({busy, done, fail}), 3'b100, "done cleared on new request");
        wait_end("R4", 1'b1);
        chk("R4", int'(mem[9]), 8'h33, "byte after retries");

        // R4 program exhausting the pulse limit
        pgm_fail_left = 1000;
        exp_pgm(2, 8'h0F, MAX_P);
        pulse_start(1'b0, 2, 8'h0F);
        wait_end("R4", 1'b0);
        chk("R4", int'(mem[2]), 8'hFF, "byte never programmed");
        pgm_fail_left = 0;

        // R5/R6/R7 erase with every byte clean after one pulse
        cur_req = "R5";
        for (int i = 0; i < N; i++) mem[i] = 8'(i * 37 + 1);
        ers_count = 0;
        exp_ers(ok);
        pulse_start(1'b1, 0, 0);
        wait_end("R7", ok);
        for (int i = 0; i < N; i++) chk("R7", int'(mem[i]), 8'hFF, "erased byte");

        // R7 erase walk with retries from middle addresses
        cur_req = "R7";
        need[5] = 3; need[11] = 2;
        ers_count = 0;
        exp_ers(ok);
        chk("R7", int'(ok), 1, "model expects pass");
        pulse_start(1'b1, 0, 0);
        wait_end("R7", 1'b1);
        chk("R7", int'(mem[15]), 8'hFF, "last byte erased");

        // R7 erase exhausting the pulse budget
        need[9] = 20;
        ers_count = 0;
        exp_ers(ok);
        chk("R7", int'(ok), 0, "model expects fail");
        pulse_start(1'b1, 0, 0);
        wait_end("R7", 1'b0);
        chk("R5", int'(mem[9]), 8'h00, "stuck byte still preprogrammed");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule